// File: doc/BRIEF.md
# Multichannel Peripheral DMA Engine

This block is a small DMA controller with a parameterised number of channels that copy bytes one beat at a time. Each channel has its own register window holding a source address, a destination address, an address behaviour for each side (count up, count down, or stay put) and a byte count. Software fills a channel's window while the channel is idle. It then writes one shared command word whose low bits pick the channels to act on and whose top bit chooses between starting and aborting them.

All active channels share a single byte mover on a request/grant memory port. A beat reads one byte at the channel's source address and then writes it to the channel's destination address. After each completed beat the round-robin arbiter passes the mover to the next active channel. The count register decrements as beats complete, so a read of it while a transfer runs returns the bytes still to move. Every channel drives two one-cycle event outputs, one for completion and one for abort, and these go to the interrupt logic.

Channel states are `CH_IDLE` and `CH_RUN`. `CH_IDLE` moves to `CH_RUN` on a start with a nonzero count. `CH_RUN` moves to `CH_IDLE` on an abort, or when the beat that takes the count to zero completes. Mover states are `MV_IDLE`, `MV_READ`, `MV_RWAIT` and `MV_WRITE`:
- `MV_IDLE` goes to `MV_READ` when any channel is running, and the arbiter picks the channel at that point.
- `MV_READ` goes to `MV_RWAIT` on the read grant.
- `MV_RWAIT` goes to `MV_WRITE` on read data valid.
- `MV_WRITE` goes back to `MV_IDLE` on the write grant.

Top module: `pdma_engine`

## Requirements
- R1: After reset every channel is idle, every channel register reads zero, `mem_req` is low and no event output is high.
- R2: A write to offset 0x000 with bit 31 clear starts each channel n whose bit n is set. A started channel with a nonzero count runs until its count reaches zero.
- R3: A write to offset 0x000 with bit 31 set aborts each channel whose bit is set. The channel is idle in the next cycle and `irq_abort[n]` pulses for one cycle. `irq_done[n]` pulses too if the channel was running. The count stays at the value it had when the abort arrived.
- R4: The mode registers hold the address behaviour in bits [5:4]: 0 increments by one per beat, 1 decrements by one per beat, and 2 or 3 keep the address fixed. The address registers read back the stepped value.
- R5: Each beat issues a read at the channel's current source address, then a write of the returned byte to its current destination address. `mem_addr` and `mem_we` hold steady while a request waits for a grant.
- R6: The count register (offset 0x30) decrements by one per completed beat. While a transfer runs, or while it is stalled, it reads as the bytes still to move.
- R7: `irq_done[n]` pulses for one cycle right after the write grant of the beat that brings the count to zero, and the channel is then idle.
- R8: A start sent to a running channel has no effect on it.
- R9: A start with a count of zero raises `irq_done[n]` in the cycle after the command write, and no bus traffic follows.
- R10: When several channels are running, beats are granted to them in turn, round-robin.
- R11: Writes to a channel's window while the channel is running are ignored.
- R12: The channel window of channel n starts at 0x100 + 0x40·n, with source mode at 0x20, destination mode at 0x24, source address at 0x28, destination address at 0x2C and count at 0x30. `reg_ready` is always high, and a read returns `reg_rdata` with `reg_rvalid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access valid |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write beat, 0 for read beat |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | 8 | Byte written |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read byte is valid |
| mem_rdata | input | 8 | Read byte |
| irq_done | output | NUM_CH | Per-channel completion pulse |
| irq_abort | output | NUM_CH | Per-channel abort pulse |

## Verification
Command effects land on the clock edge that samples the write. The bench therefore samples the event outputs at the falling edge just after its write task returns, and expects a zero-count done or an abort pulse at exactly that point. Register read data is due one cycle after the request, and the read task samples it at the next falling edge. Beat progress depends on random grant delays, so the bench logs every granted read and write at the falling edge, compares the log with addresses and bytes it computes from the programmed modes, and waits on counted done pulses rather than on fixed cycle numbers. For the live-count, busy-start and busy-write cases, the grants are held off first so that the count is frozen when it is read.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        AM_INC   = 2'd0,
        AM_DEC   = 2'd1,
        AM_FIXED = 2'd2,
        AM_HOLD  = 2'd3
    } addr_mode_e;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_READ,
        MV_RWAIT,
        MV_WRITE
    } mv_state_e;

    localparam logic [5:0] OFF_SRC_MODE = 6'h20;
    localparam logic [5:0] OFF_DST_MODE = 6'h24;
    localparam logic [5:0] OFF_SRC_ADDR = 6'h28;
    localparam logic [5:0] OFF_DST_ADDR = 6'h2C;
    localparam logic [5:0] OFF_COUNT    = 6'h30;

    localparam int CMD_ABORT_BIT = 31;
    localparam int WIN_BASE      = 'h100;
    localparam int WIN_SHIFT     = 6;

endpackage

// File: rtl/pdma_rr_arb.sv
module pdma_rr_arb #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic              take,
    output logic              any,
    output logic [CH_W-1:0]   idx
);

    logic [CH_W-1:0] last_q;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int cand;
            cand = (int'(last_q) + k) % NUM_CH;
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = CH_W'(cand);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= CH_W'(NUM_CH - 1);
        end else if (take && any) begin
            last_q <= idx;
        end
    end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [5:0]    cfg_off,
    input  logic [31:0]   cfg_wdata,
    input  logic          start,
    input  logic          abort,
    input  logic          beat_done,
    output logic          busy,
    output addr_mode_e    src_mode,
    output addr_mode_e    dst_mode,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] remain,
    output logic          ev_done,
    output logic          ev_abort
);

    ch_state_e state_q, state_d;

    function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, addr_mode_e m);
        unique case (m)
            AM_INC:  return a + AW'(1);
            AM_DEC:  return a - AW'(1);
            default: return a;
        endcase
    endfunction

    logic last_beat;
    logic beat_ok;
    assign beat_ok   = (state_q == CH_RUN) && beat_done && !abort;
    assign last_beat = beat_ok && (remain == CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start && (remain != '0)) state_d = CH_RUN;
            CH_RUN: begin
                if (abort)          state_d = CH_IDLE;
                else if (last_beat) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_mode <= AM_INC;
            dst_mode <= AM_INC;
            src_addr <= '0;
            dst_addr <= '0;
            remain   <= '0;
        end else if (state_q == CH_IDLE && cfg_we) begin
            unique case (cfg_off)
                OFF_SRC_MODE: src_mode <= addr_mode_e'(cfg_wdata[5:4]);
                OFF_DST_MODE: dst_mode <= addr_mode_e'(cfg_wdata[5:4]);
                OFF_SRC_ADDR: src_addr <= cfg_wdata[AW-1:0];
                OFF_DST_ADDR: dst_addr <= cfg_wdata[AW-1:0];
                OFF_COUNT:    remain   <= cfg_wdata[CW-1:0];
                default: ;
            endcase
        end else if (beat_ok) begin
            src_addr <= next_addr(src_addr, src_mode);
            dst_addr <= next_addr(dst_addr, dst_mode);
            remain   <= remain - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_done  <= 1'b0;
            ev_abort <= 1'b0;
        end else begin
            ev_done  <= ((state_q == CH_IDLE) && start && (remain == '0))
                      || ((state_q == CH_RUN) && abort)
                      || last_beat;
            ev_abort <= abort;
        end
    end

    assign busy = (state_q == CH_RUN);

endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
    import pdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int CH_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          busy,
    input  logic [NUM_CH-1:0]          abort_vec,
    input  logic [NUM_CH-1:0][AW-1:0]  src_addrs,
    input  logic [NUM_CH-1:0][AW-1:0]  dst_addrs,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [7:0]                 mem_wdata,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    input  logic [7:0]                 mem_rdata,
    output logic [NUM_CH-1:0]          beat_vec
);

    mv_state_e       state_q, state_d;
    logic [CH_W-1:0] cur_q;
    logic            live_q;
    logic [AW-1:0]   src_q, dst_q;
    logic [7:0]      byte_q;
    logic            arb_any;
    logic [CH_W-1:0] arb_idx;
    logic            take;

    assign take = (state_q == MV_IDLE) && arb_any;

    pdma_rr_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (busy),
        .take  (take),
        .any   (arb_any),
        .idx   (arb_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MV_IDLE:  if (arb_any)    state_d = MV_READ;
            MV_READ:  if (mem_gnt)    state_d = MV_RWAIT;
            MV_RWAIT: if (mem_rvalid) state_d = MV_WRITE;
            MV_WRITE: if (mem_gnt)    state_d = MV_IDLE;
            default:                  state_d = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            live_q <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            byte_q <= '0;
        end else begin
            if (take) begin
                cur_q  <= arb_idx;
                live_q <= !abort_vec[arb_idx];
                src_q  <= src_addrs[arb_idx];
                dst_q  <= dst_addrs[arb_idx];
            end else if (abort_vec[cur_q]) begin
                live_q <= 1'b0;
            end
            if (state_q == MV_RWAIT && mem_rvalid) byte_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = (state_q == MV_READ) || (state_q == MV_WRITE);
        mem_we    = (state_q == MV_WRITE);
        mem_addr  = (state_q == MV_WRITE) ? dst_q : src_q;
        mem_wdata = byte_q;
        beat_vec  = '0;
        if (state_q == MV_WRITE && mem_gnt && live_q) beat_vec[cur_q] = 1'b1;
    end

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int CW     = 16,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ready,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic [NUM_CH-1:0] irq_done,
    output logic [NUM_CH-1:0] irq_abort
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_W = REG_AW - WIN_SHIFT;

    logic [WIN_W-1:0]            win_idx;
    logic [5:0]                  win_off;
    logic                        in_win;
    logic                        cmd_hit;
    logic [NUM_CH-1:0]           start_vec, abort_vec, busy_vec, beat_vec;
    logic [NUM_CH-1:0][AW-1:0]   src_a, dst_a;
    logic [NUM_CH-1:0][CW-1:0]   remain_a;
    addr_mode_e                  src_m [NUM_CH];
    addr_mode_e                  dst_m [NUM_CH];
    logic [31:0]                 rd_next;

    wire unused_cmd_bits = ^reg_wdata[CMD_ABORT_BIT-1:NUM_CH];

    assign win_idx = reg_addr[REG_AW-1:WIN_SHIFT] - WIN_W'(WIN_BASE >> WIN_SHIFT);
    assign win_off = reg_addr[5:0];
    assign in_win  = (reg_addr >= REG_AW'(WIN_BASE)) && (win_idx < WIN_W'(NUM_CH));
    assign cmd_hit = reg_req && reg_we && (reg_addr == '0);

    assign start_vec = (cmd_hit && !reg_wdata[CMD_ABORT_BIT]) ? reg_wdata[NUM_CH-1:0] : '0;
    assign abort_vec = (cmd_hit &&  reg_wdata[CMD_ABORT_BIT]) ? reg_wdata[NUM_CH-1:0] : '0;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic win_we;
        assign win_we = reg_req && reg_we && in_win && (win_idx == WIN_W'(n));

        pdma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (win_we),
            .cfg_off   (win_off),
            .cfg_wdata (reg_wdata),
            .start     (start_vec[n]),
            .abort     (abort_vec[n]),
            .beat_done (beat_vec[n]),
            .busy      (busy_vec[n]),
            .src_mode  (src_m[n]),
            .dst_mode  (dst_m[n]),
            .src_addr  (src_a[n]),
            .dst_addr  (dst_a[n]),
            .remain    (remain_a[n]),
            .ev_done   (irq_done[n]),
            .ev_abort  (irq_abort[n])
        );
    end

    pdma_mover #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy_vec),
        .abort_vec  (abort_vec),
        .src_addrs  (src_a),
        .dst_addrs  (dst_a),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .beat_vec   (beat_vec)
    );

    always_comb begin
        rd_next = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (in_win && win_idx == WIN_W'(n)) begin
                unique case (win_off)
                    OFF_SRC_MODE: rd_next = {26'b0, src_m[n], 4'b0};
                    OFF_DST_MODE: rd_next = {26'b0, dst_m[n], 4'b0};
                    OFF_SRC_ADDR: rd_next = 32'(src_a[n]);
                    OFF_DST_ADDR: rd_next = 32'(dst_a[n]);
                    OFF_COUNT:    rd_next = 32'(remain_a[n]);
                    default:      rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_req && !reg_we;
            reg_rdata  <= (reg_req && !reg_we) ? rd_next : '0;
        end
    end

    assign reg_ready = 1'b1;

endmodule

// File: rtl/pdma_engine_chk.sv
module pdma_engine_chk #(
    parameter int NUM_CH = 4,
    parameter int AW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic              reg_rvalid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [AW-1:0]     mem_addr,
    input logic [NUM_CH-1:0] irq_done,
    input logic [NUM_CH-1:0] irq_abort,
    input logic [NUM_CH-1:0] busy_vec,
    input logic [NUM_CH-1:0] abort_vec,
    input logic [NUM_CH-1:0] beat_vec
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R5

    AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> reg_rvalid); // R12

    AST_NO_SPUR_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_we) |=> !reg_rvalid); // R12

    AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort_vec) |=> ((busy_vec & $past(abort_vec)) == '0)); // R3

    AST_ABORT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_abort) |-> (irq_abort == $past(abort_vec))); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_done) |-> ((busy_vec & irq_done) == '0)); // R7

    AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(beat_vec)); // R10

    AST_BEAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|beat_vec) |-> ((beat_vec & ~busy_vec) == '0)); // R6

endmodule

bind pdma_engine pdma_engine_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_rvalid (reg_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .irq_done   (irq_done),
    .irq_abort  (irq_abort),
    .busy_vec   (busy_vec),
    .abort_vec  (abort_vec),
    .beat_vec   (beat_vec)
);

// File: tb/pdma_engine_bench.sv
`timescale 1ns/1ps
module pdma_engine_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ready, reg_rvalid;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [NCH-1:0] irq_done, irq_abort;

    always #2.5 clk = ~clk;

    pdma_engine u_pdma_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .irq_done(irq_done), .irq_abort(irq_abort)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic hold = 1'b0;
    logic [31:0] wr_addr_log [0:1023];
    logic [7:0]  wr_data_log [0:1023];
    logic [31:0] rd_addr_log [0:1023];
    int wr_cnt = 0, rd_cnt = 0, served = 0;
    int done_cnt [NCH];
    int abort_cnt [NCH];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] step(logic [31:0] a, int m);
        if (m == 0) return a + 1;
        if (m == 1) return a - 1;
        return a;
    endfunction

    function automatic logic [11:0] win(int ch, logic [5:0] off);
        return 12'h100 + 12'(ch * 'h40) + 12'(off);
    endfunction

    // Bus log at the falling edge, one-cycle read responder after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    if (wr_cnt < 1024) begin
                        wr_addr_log[wr_cnt] = mem_addr;
                        wr_data_log[wr_cnt] = mem_wdata;
                    end
                    wr_cnt++;
                end else begin
                    if (rd_cnt < 1024) rd_addr_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                done_cnt[c]  += int'(irq_done[c]);
                abort_cnt[c] += int'(irq_abort[c]);
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rd_cnt != served) begin
            mem_rvalid = 1'b1;
            mem_rdata  = pat(rd_addr_log[served]);
            served     = rd_cnt;
        end else begin
            mem_rvalid = 1'b0;
        end
        mem_gnt = mem_req && !hold && (($urandom % 4) != 0);
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_done(int ch, int target);
        int t = 0;
        while (done_cnt[ch] < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic run_one(int ch, int sm, int dm, logic [31:0] sa, logic [31:0] da, int n);
        int base, rbase, d0;
        logic [31:0] s, d, rv;
        reg_wr(win(ch, 6'h20), 32'(sm) << 4);
        reg_wr(win(ch, 6'h24), 32'(dm) << 4);
        reg_wr(win(ch, 6'h28), sa);
        reg_wr(win(ch, 6'h2C), da);
        reg_wr(win(ch, 6'h30), 32'(n));
        base = wr_cnt; rbase = rd_cnt; d0 = done_cnt[ch];
        reg_wr(12'h000, 32'(1) << ch);
        wait_done(ch, d0 + 1);
        check("R7 done count", 32'(done_cnt[ch]), 32'(d0 + 1));
        check("R2 beats moved", 32'(wr_cnt - base), 32'(n));
        s = sa; d = da;
        for (int k = 0; k < n; k++) begin
            check("R5 read addr", rd_addr_log[rbase + k], s);
            check("R5 write addr", wr_addr_log[base + k], d);
            check("R5 write data", 32'(wr_data_log[base + k]), 32'(pat(s)));
            s = step(s, sm); d = step(d, dm);
        end
        reg_rd(win(ch, 6'h28), rv); check("R4 final src", rv, s);
        reg_rd(win(ch, 6'h2C), rv); check("R4 final dst", rv, d);
        reg_rd(win(ch, 6'h30), rv); check("R6 final count", rv, 32'd0);
        reg_rd(win(ch, 6'h20), rv); check("R12 src mode readback", rv, 32'(sm) << 4);
    endtask

    initial begin
        logic [31:0] rv, exp_rem;
        int unsigned seed_v;
        int base, d0, a0;
        seed_v = $urandom(32'd4242);
        for (int c = 0; c < NCH; c++) begin done_cnt[c] = 0; abort_cnt[c] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 irq_done", 32'(irq_done), 32'd0);
        check("R1 irq_abort", 32'(irq_abort), 32'd0);
        reg_rd(win(0, 6'h30), rv); check("R1 count", rv, 32'd0);
        reg_rd(win(3, 6'h28), rv); check("R1 src addr", rv, 32'd0);
        check("R12 rvalid", 32'(reg_rvalid), 32'd1);
        check("R12 ready", 32'(reg_ready), 32'd1);

        // R12 window placement
        reg_wr(win(1, 6'h2C), 32'hDEAD_0123);
        reg_rd(win(1, 6'h2C), rv); check("R12 dst addr window", rv, 32'hDEAD_0123);
        reg_rd(win(2, 6'h2C), rv); check("R12 other window", rv, 32'd0);

        // R4 R5 directed modes
        run_one(0, 0, 2, 32'h0000_0040, 32'h0000_0800, 4);
        run_one(1, 1, 0, 32'h0000_1210, 32'h0000_2000, 5);
        run_one(2, 3, 1, 32'h0000_0077, 32'h0000_3010, 3);

        // Random transfers
        for (int i = 0; i < 10; i++) begin
            run_one(int'($urandom % NCH), int'($urandom % 4), int'($urandom % 4),
                    $urandom & 32'hFFFF, $urandom & 32'hFFFF, 1 + int'($urandom % 12));
        end

        // R6 R8 R11 R3 live count, busy start, busy write, abort
        reg_wr(win(2, 6'h20), 32'h0);
        reg_wr(win(2, 6'h24), 32'h0);
        reg_wr(win(2, 6'h28), 32'h300);
        reg_wr(win(2, 6'h2C), 32'h3000);
        reg_wr(win(2, 6'h30), 32'd40);
        base = wr_cnt; d0 = done_cnt[2]; a0 = abort_cnt[2];
        reg_wr(12'h000, 32'h4);
        while (wr_cnt - base < 5) @(negedge clk);
        hold = 1'b1;
        repeat (4) @(negedge clk);
        exp_rem = 32'(40 - (wr_cnt - base));
        reg_rd(win(2, 6'h30), rv); check("R6 live count", rv, exp_rem);
        reg_wr(12'h000, 32'h4);
        reg_rd(win(2, 6'h30), rv); check("R8 start while busy", rv, exp_rem);
        reg_wr(win(2, 6'h30), 32'd5);
        reg_rd(win(2, 6'h30), rv); check("R11 write while busy", rv, exp_rem);
        reg_wr(12'h000, 32'h8000_0004);
        check("R3 abort pulse", 32'(irq_abort[2]), 32'd1);
        check("R3 done pulse on abort", 32'(irq_done[2]), 32'd1);
        hold = 1'b0;
        repeat (12) @(negedge clk);
        reg_rd(win(2, 6'h30), rv); check("R3 count frozen", rv, exp_rem);
        check("R3 abort events", 32'(abort_cnt[2] - a0), 32'd1);
        check("R8 no extra done", 32'(done_cnt[2] - d0), 32'd1);

        // R9 zero count start
        reg_wr(win(3, 6'h30), 32'd0);
        base = wr_cnt;
        reg_wr(12'h000, 32'h8);
        check("R9 immediate done", 32'(irq_done[3]), 32'd1);
        repeat (6) @(negedge clk);
        check("R9 no traffic", 32'(wr_cnt - base), 32'd0);

        // R3 abort of idle channel
        reg_wr(12'h000, 32'h8000_0008);
        check("R3 idle abort pulse", 32'(irq_abort[3]), 32'd1);
        check("R3 idle abort no done", 32'(irq_done[3]), 32'd0);

        // R10 R2 two channels started together
        reg_wr(win(0, 6'h20), 32'h0); reg_wr(win(0, 6'h24), 32'h0);
        reg_wr(win(0, 6'h28), 32'h10); reg_wr(win(0, 6'h2C), 32'h1000);
        reg_wr(win(0, 6'h30), 32'd6);
        reg_wr(win(1, 6'h20), 32'h0); reg_wr(win(1, 6'h24), 32'h0);
        reg_wr(win(1, 6'h28), 32'h20); reg_wr(win(1, 6'h2C), 32'h2000);
        reg_wr(win(1, 6'h30), 32'd6);
        base = wr_cnt; d0 = done_cnt[0]; a0 = done_cnt[1];
        reg_wr(12'h000, 32'h3);
        wait_done(0, d0 + 1);
        wait_done(1, a0 + 1);
        check("R2 both done", 32'(done_cnt[0] - d0 + done_cnt[1] - a0), 32'd2);
        check("R2 beats total", 32'(wr_cnt - base), 32'd12);
        for (int k = 1; k < 12; k++) begin
            check("R10 alternation", 32'(wr_addr_log[base + k][13:12] != wr_addr_log[base + k - 1][13:12]), 32'd1);
        end

        summary();
        $finish;
    end

endmodule